// File: doc/BRIEF.md
# Lane Parity Generator and Checker

This block sits on the read side of a first-in first-out data path whose word is built from 9-bit lanes. In every lane, bits 7:0 carry data and bit 8 is the parity position, so for a four-lane word the parity positions are bits 8, 17, 26 and 35. Depending on a 3-bit mode, the block either passes stored words through unchanged, replaces each lane's top bit with a freshly computed even or odd parity bit, or replaces it with a pass/fail indication from checking even or odd parity over all nine lane bits. In check mode a low level on a lane's top bit marks a parity error.

The mode is programmed through the ordinary write port while master reset is held low. Each clock edge that sees reset low and write enable high takes the three low write-data bits as the new mode. A reset during which write enable never rises leaves parity disabled. While reset is low, the read port shows the captured mode word so that the programming can be confirmed. Once reset is released the mode stays fixed until the next reset; normal data writes do not touch it. The number of lanes is a parameter (1, 2 or 4, for 9-, 18- or 36-bit words).

Top module: `lane_parity_unit`

## Requirements
- R1: Mode encoding: when mode bit 2 is 0 (modes 000 to 011), parity is disabled and `rd_data` equals `fifo_q` on every bit.
- R2: Mode 100 (generate, even sense): the top bit of each lane (bit 9*i+8) equals the XOR of that lane's bits 7:0.
- R3: Mode 101 (generate, odd sense): the top bit of each lane equals the inverted XOR of that lane's bits 7:0.
- R4: Mode 110 (check, even sense): the top bit of each lane is 1 when the XOR of all nine lane bits of `fifo_q` is 0 and is 0 (error) otherwise.
- R5: Mode 111 (check, odd sense): the top bit of each lane is 1 when the XOR of all nine lane bits of `fifo_q` is 1 and is 0 (error) otherwise.
- R6: Outside reset, bits 7:0 of every lane of `rd_data` always equal the same bits of `fifo_q`, and each lane's top bit depends only on its own lane.
- R7: A rising clock edge with `rst_n` low and `wr_en` high loads `wr_data_lo` as the mode; when several such writes occur in one reset, the last one is kept, and idle reset cycles after it do not change it.
- R8: A reset during which `wr_en` stays low on every clock edge leaves the mode at 000 (parity disabled), whatever mode was in force before.
- R9: While `rst_n` is low, `rd_data` bits 2:0 show the mode word as captured by the latest clock edge and all higher bits are 0.
- R10: With `rst_n` high, writes (`wr_en` high with any `wr_data_lo`) never change the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the mode capture and the read path |
| rst_n | input | 1 | Master reset, active low; mode programming happens while it is low |
| wr_en | input | 1 | Write enable, active high |
| wr_data_lo | input | 3 | Low three bits of the write-port data, taken as the mode during reset |
| fifo_q | input | 9*LANES | Word arriving from storage on the read side |
| rd_data | output | 9*LANES | Read-port word after parity generation or checking, or the mode readback during reset |

## Verification
The assertions watch on every cycle that the data bits of each lane pass through untouched, that the top bit of each lane follows the generate or check rule of the mode in force, that disabled modes pass the word through, that the mode never moves outside reset, and that a reset write shows up on the readback at the next edge. What only the bench scenarios can show is the sequencing of programming: that the last of several reset writes wins, that a write-free reset clears an earlier mode back to disabled, and that heavy write traffic after release leaves the programmed behaviour intact across many random words with single-lane corruptions.

// File: rtl/lpar_pkg.sv
package lpar_pkg;

   localparam int unsigned LANE_BITS = 9;
   localparam int unsigned DATA_BITS = 8;
   localparam int unsigned MODE_BITS = 3;

   typedef enum logic [1:0] {
      PAR_OFF = 2'd0,
      PAR_GEN = 2'd1,
      PAR_CHK = 2'd2
   } par_op_e;

   typedef struct packed {
      par_op_e op;
      logic    odd;
   } par_cfg_t;

   // bit 2 enables parity, bit 1 picks check over generate, bit 0 picks odd sense
   function automatic par_cfg_t decode_mode(input logic [MODE_BITS-1:0] m);
      par_cfg_t c;
      c.odd = m[0];
      if (!m[2])
         c.op = PAR_OFF;
      else if (m[1])
         c.op = PAR_CHK;
      else
         c.op = PAR_GEN;
      return c;
   endfunction

endpackage

// File: rtl/lpar_mode_reg.sv
module lpar_mode_reg
   import lpar_pkg::*;
#(
   parameter int unsigned MW = MODE_BITS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [MW-1:0] wr_word,
   output logic [MW-1:0] mode_q
);

   // pend_q is cleared on every clock outside reset, so each reset starts
   // from "nothing captured" and falls back to the disabled mode
   logic [MW-1:0] pend_q;
   logic [MW-1:0] pend_d;

   always_comb begin
      pend_d = wr_en ? wr_word : pend_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= pend_d;
         mode_q <= pend_d;
      end else begin
         pend_q <= '0;
      end
   end

endmodule

// File: rtl/lpar_lane.sv
module lpar_lane
   import lpar_pkg::*;
(
   input  par_cfg_t             cfg,
   input  logic [LANE_BITS-1:0] lane_in,
   output logic [LANE_BITS-1:0] lane_out
);

   logic sum_data;
   logic sum_all;

   always_comb begin
      sum_data = ^lane_in[DATA_BITS-1:0];
      sum_all  = sum_data ^ lane_in[LANE_BITS-1];
      lane_out = lane_in;
      unique case (cfg.op)
         PAR_GEN: lane_out[LANE_BITS-1] = sum_data ^ cfg.odd;
         PAR_CHK: lane_out[LANE_BITS-1] = sum_all ^ ~cfg.odd;
         default: lane_out[LANE_BITS-1] = lane_in[LANE_BITS-1];
      endcase
   end

endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
   import lpar_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [MODE_BITS-1:0]         wr_data_lo,
   input  logic [LANES*LANE_BITS-1:0]   fifo_q,
   output logic [LANES*LANE_BITS-1:0]   rd_data
);

   localparam int unsigned W = LANES * LANE_BITS;

   generate
      if (!(LANES == 1 || LANES == 2 || LANES == 4)) begin : g_bad_lanes
         $error("lane_parity_unit: LANES must be 1, 2 or 4");
      end
      if (W <= MODE_BITS) begin : g_bad_width
         $error("lane_parity_unit: word too narrow for mode readback");
      end
   endgenerate

   logic [MODE_BITS-1:0] mode_q;
   par_cfg_t             cfg;
   logic [W-1:0]         lanes_out;

   lpar_mode_reg #(.MW(MODE_BITS)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_word (wr_data_lo),
      .mode_q  (mode_q)
   );

   always_comb begin
      cfg = decode_mode(mode_q);
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         lpar_lane u_lane (
            .cfg      (cfg),
            .lane_in  (fifo_q[i*LANE_BITS +: LANE_BITS]),
            .lane_out (lanes_out[i*LANE_BITS +: LANE_BITS])
         );
      end
   endgenerate

   always_comb begin
      if (!rst_n)
         rd_data = {{(W-MODE_BITS){1'b0}}, mode_q};
      else
         rd_data = lanes_out;
   end

endmodule

// File: rtl/lane_parity_chk.sv
module lane_parity_chk
   import lpar_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         wr_en,
   input logic [MODE_BITS-1:0]         wr_data_lo,
   input logic [LANES*LANE_BITS-1:0]   fifo_q,
   input logic [LANES*LANE_BITS-1:0]   rd_data,
   input logic [MODE_BITS-1:0]         mode_q
);

   localparam int unsigned W = LANES * LANE_BITS;

   // R1: disabled modes pass the stored word through
   p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2] == 1'b0) |-> (rd_data == fifo_q));

   // R10: mode frozen outside reset
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(mode_q));

   // R9 / R7: a reset write appears on the readback at the next edge
   p_readback_r9: assert property (@(posedge clk)
      (!rst_n && wr_en) |=> (rst_n || (rd_data == W'($past(wr_data_lo)))));

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_ln
         // R6: data bits of a lane are untouched
         p_lowbits_r6: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[i*LANE_BITS +: DATA_BITS] == fifo_q[i*LANE_BITS +: DATA_BITS]);

         // R2
         p_gen_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == 3'b100) |->
            (rd_data[i*LANE_BITS+8] == ^fifo_q[i*LANE_BITS +: DATA_BITS]));

         // R3
         p_gen_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == 3'b101) |->
            (rd_data[i*LANE_BITS+8] == ~^fifo_q[i*LANE_BITS +: DATA_BITS]));

         // R4
         p_chk_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == 3'b110) |->
            (rd_data[i*LANE_BITS+8] == ~^fifo_q[i*LANE_BITS +: LANE_BITS]));

         // R5
         p_chk_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == 3'b111) |->
            (rd_data[i*LANE_BITS+8] == ^fifo_q[i*LANE_BITS +: LANE_BITS]));
      end
   endgenerate

endmodule

bind lane_parity_unit lane_parity_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_lane_parity_unit.sv
module tb_lane_parity_unit;
   import lpar_pkg::*;

   localparam int unsigned LANES = 4;
   localparam int unsigned W     = LANES * LANE_BITS;

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic                 wr_en;
   logic [MODE_BITS-1:0] wr_data_lo;
   logic [W-1:0]         fifo_q;
   logic [W-1:0]         rd_data;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;
   logic [2:0] cur_mode;

   always #2.5 clk = ~clk;

   lane_parity_unit #(.LANES(LANES)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data_lo (wr_data_lo),
      .fifo_q     (fifo_q),
      .rd_data    (rd_data)
   );

   function automatic logic [W-1:0] model(input logic [2:0] m, input logic [W-1:0] q);
      logic [W-1:0] r;
      r = q;
      for (int i = 0; i < LANES; i++) begin
         logic [8:0] ln;
         ln = q[i*9 +: 9];
         if (m[2]) begin
            if (!m[1]) r[i*9+8] = m[0] ? ~(^ln[7:0]) : ^ln[7:0];
            else       r[i*9+8] = m[0] ? (^ln) : ~(^ln);
         end
      end
      return r;
   endfunction

   function automatic string mode_tag(input logic [2:0] m);
      if (!m[2])          return "R1";
      else if (m == 3'b100) return "R2";
      else if (m == 3'b101) return "R3";
      else if (m == 3'b110) return "R4";
      else                  return "R5";
   endfunction

   function automatic logic [W-1:0] rand_word();
      logic [63:0] v;
      v = {$urandom, $urandom};
      return v[W-1:0];
   endfunction

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // program through a reset; list of writes given by count and two values
   task automatic program_reset(input int nwr, input logic [2:0] m1, input logic [2:0] m2);
      logic [2:0] exp_m;
      exp_m = 3'b000;
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = (nwr > 0);
      wr_data_lo = m1;
      if (nwr > 0) exp_m = m1;
      @(negedge clk);
      if (nwr > 1) begin
         wr_en = 1'b1;
         wr_data_lo = m2;
         exp_m = m2;
         @(negedge clk);
      end
      wr_en = 1'b0;
      wr_data_lo = 3'($urandom);
      fifo_q = rand_word();
      #1;
      check(rd_data == W'(exp_m), (nwr == 0) ? "R8 R9" : "R7 R9", rd_data, W'(exp_m));
      @(negedge clk);
      #1;
      // idle reset cycles keep the capture (R7), upper bits zero (R9)
      check(rd_data == W'(exp_m), "R7 R9 idle", rd_data, W'(exp_m));
      rst_n = 1'b1;
      cur_mode = exp_m;
   endtask

   task automatic drive_check(input logic [W-1:0] q, input bit wen, input string extra);
      logic [W-1:0] e;
      @(negedge clk);
      fifo_q = q;
      wr_en = wen;
      wr_data_lo = 3'($urandom);
      #1;
      e = model(cur_mode, q);
      check(rd_data == e, {mode_tag(cur_mode), " ", extra}, rd_data, e);
   endtask

   task automatic traffic(input int n);
      for (int k = 0; k < n; k++) begin
         drive_check(rand_word(), 1'($urandom), "R6 R10");
      end
   endtask

   task automatic directed();
      drive_check('0, 1'b0, "R6 zeros");
      drive_check('1, 1'b1, "R6 ones");
      // flip one bit in lane 2 only: other lanes' top bits must not move
      drive_check(W'(1) << 19, 1'b0, "R6 single lane");
      drive_check(W'(1) << 8, 1'b1, "R6 top bit only");
   endtask

   initial begin : main
      void'($urandom(32'h5A17));
      rst_n = 1'b1;
      wr_en = 1'b0;
      wr_data_lo = '0;
      fifo_q = '0;
      cur_mode = 3'b000;
      repeat (2) @(negedge clk);

      // reset state: a write-free reset yields the disabled mode
      program_reset(0, 3'b000, 3'b000);
      directed();
      traffic(100);

      for (int m = 4; m < 8; m++) begin
         program_reset(1, 3'(m), 3'b000);
         directed();
         traffic(200);
      end

      // a disabled code with bit 2 clear but other bits set
      program_reset(1, 3'b011, 3'b000);
      directed();
      traffic(100);

      // last of two reset writes wins
      program_reset(2, 3'b100, 3'b111);
      directed();
      traffic(150);

      // write-free reset clears the previous check mode
      program_reset(0, 3'b000, 3'b000);
      drive_check(W'(36'h1_0000_0001), 1'b1, "R8 cleared");
      traffic(100);

      // a second pair of writes in the other order
      program_reset(2, 3'b110, 3'b101);
      directed();
      traffic(150);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

endmodule